// File: doc/BRIEF.md
# Multi-Cycle Load/Register Processor Core

This block is a small register-machine core. It runs every instruction as a fixed walk through register-transfer steps: fetch, decode, execute, memory and write-back. It reaches memory only through two internal registers. The memory address register drives the address pins. The memory data register captures the words that a data read returns. Instruction words come back through the same read port and are latched into the instruction register. The core has sixteen 32-bit general registers and four operations: register add, load with a signed displacement, branch-if-not-zero with a PC-relative offset, and halt.

Memory sits outside the block as a synchronous read port with one cycle of latency. The core raises a read strobe for one cycle with the address register on the address pins. The memory drives the addressed word on the following cycle. Each memory access therefore spends three steps: set the address, let the memory cycle, capture the data. An add or a branch takes 7 cycles and a load takes 8. A combinational register-peek port shows any general register, so results can be checked once the program halts.

Top module: `mc_core`

## Requirements
- R1: Instruction words use this layout: bits 31:28 hold the opcode, 27:24 the first source register, 23:20 the second source register, 19:16 the destination register, and 15:0 a two's-complement immediate. Opcode 1 is add, 2 is load, 3 is branch-if-not-zero and 15 is halt.
- R2: While reset is held and right after it is released, all general registers read 0, halted is 0 and no read is issued. The first fetch after reset is from byte address 0.
- R3: Each instruction begins with a fetch. The cycle after the step starts, mem_rd is high for exactly one cycle and mem_addr equals the PC. The word returned one cycle later becomes the instruction.
- R4: Apart from a taken branch, the address of the next fetch is 4 more than the address of the current instruction.
- R5: An add writes (first source + second source) mod 2^32 to the destination register, issues no data read and takes 7 cycles.
- R6: A load issues a single data read in its sixth cycle, at the address first source + sign-extended immediate. It writes the returned word to the destination register and takes 8 cycles.
- R7: A branch-if-not-zero takes 7 cycles and issues no data read. When the first source is nonzero, the next fetch is from the instruction address + 4 + sign-extended immediate. Otherwise execution falls through.
- R8: Opcodes other than 1, 2, 3 and 15 take 7 cycles, issue no data read and change no register.
- R9: A halt raises halted from the cycle after its decode step. Halted stays high, with no further reads, until reset.
- R10: reg_val shows the general register selected by reg_sel, combinationally.
- R11: A loop that starts from r1=100, r3=1, r4=0 and repeatedly adds r3 into r4, adds 2 to r3 and decrements r1 until r1 is zero ends with r4 = 10000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Byte address from the memory address register |
| mem_rd | output | 1 | Read command, one cycle per access |
| mem_rdata | input | 32 | Word returned one cycle after the read command |
| reg_sel | input | 4 | General register selected for observation |
| reg_val | output | 32 | Value of the selected register |
| halted | output | 1 | High once a halt has been decoded |

## Verification
Two programs are run, and a behavioural instruction-level model predicts mem_rd, mem_addr and halted for every cycle. The counting loop stresses the backward taken branch and its final fall-through. Across a hundred iterations it accumulates a value whose total exposes any lost add or a miscounted iteration. The second program loads through a negative displacement from a nonzero base, executes an undefined opcode, and branches both not-taken on a zero register and forward-taken over a load. Register contents are then compared through the peek port, which separates a wrong write destination or a skipped write-back from a wrong address or timing.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int XLEN  = 32;
    localparam int RIDX  = 4;
    localparam int NREG  = 1 << RIDX;
    localparam int OPW   = 4;
    localparam int IMMW  = XLEN - OPW - 3 * RIDX;
    localparam int PCINC = XLEN / 8;

    localparam logic [OPW-1:0] OPC_ADD  = 4'd1;
    localparam logic [OPW-1:0] OPC_LD   = 4'd2;
    localparam logic [OPW-1:0] OPC_BNZ  = 4'd3;
    localparam logic [OPW-1:0] OPC_HALT = 4'd15;

    typedef struct packed {
        logic [OPW-1:0]  opc;
        logic [RIDX-1:0] rs1;
        logic [RIDX-1:0] rs2;
        logic [RIDX-1:0] rd;
        logic [IMMW-1:0] imm;
    } instr_t;

    typedef enum logic [3:0] {
        ST_IF, ST_IFW, ST_IFL, ST_ID, ST_EX, ST_MEM, ST_MEMW, ST_WB, ST_HALT
    } step_e;

    typedef struct packed {
        step_e           step;
        logic [XLEN-1:0] pc;
        instr_t          ir;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] alu;
        logic [XLEN-1:0] mar;
        logic [XLEN-1:0] mdr;
        logic            rd;
        logic            cond;
    } core_t;
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_dbg,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    output logic [DW-1:0] rd_dbg
);
    localparam int N = 1 << AW;

    logic [DW-1:0] regs_q [N];
    logic [DW-1:0] regs_d [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign rd_a   = regs_q[ra_a];
    assign rd_b   = regs_q[ra_b];
    assign rd_dbg = regs_q[ra_dbg];
endmodule

// File: rtl/mc_alu.sv
module mc_alu #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic [DW-1:0] tst,
    output logic [DW-1:0] sum,
    output logic          nonzero
);
    assign sum     = x + y;
    assign nonzero = |tst;
endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] mem_addr,
    output logic            mem_rd,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic [RIDX-1:0] reg_sel,
    output logic [XLEN-1:0] reg_val,
    output logic            halted
);
    core_t cur_q, nxt_d;

    logic            wr_en_d;
    logic [XLEN-1:0] wr_data_d;
    logic [XLEN-1:0] src_a, src_b;
    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] alu_x, alu_y, alu_sum;
    logic            alu_nz;

    mc_regfile #(.DW(XLEN), .AW(RIDX)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en_d),
        .waddr  (cur_q.ir.rd),
        .wdata  (wr_data_d),
        .ra_a   (cur_q.ir.rs1),
        .ra_b   (cur_q.ir.rs2),
        .ra_dbg (reg_sel),
        .rd_a   (src_a),
        .rd_b   (src_b),
        .rd_dbg (reg_val)
    );

    assign imm_sx = {{(XLEN-IMMW){cur_q.ir.imm[IMMW-1]}}, cur_q.ir.imm};
    assign alu_x  = (cur_q.ir.opc == OPC_BNZ) ? cur_q.pc : cur_q.a;
    assign alu_y  = (cur_q.ir.opc == OPC_ADD) ? cur_q.b  : imm_sx;

    mc_alu #(.DW(XLEN)) u_alu (
        .x       (alu_x),
        .y       (alu_y),
        .tst     (cur_q.a),
        .sum     (alu_sum),
        .nonzero (alu_nz)
    );

    always_comb begin
        nxt_d     = cur_q;
        wr_en_d   = 1'b0;
        wr_data_d = cur_q.alu;
        unique case (cur_q.step)
            ST_IF: begin
                nxt_d.mar  = cur_q.pc;
                nxt_d.rd   = 1'b1;
                nxt_d.step = ST_IFW;
            end
            ST_IFW: begin
                nxt_d.rd   = 1'b0;
                nxt_d.step = ST_IFL;
            end
            ST_IFL: begin
                nxt_d.ir   = instr_t'(mem_rdata);
                nxt_d.step = ST_ID;
            end
            ST_ID: begin
                nxt_d.a    = src_a;
                nxt_d.b    = src_b;
                nxt_d.pc   = cur_q.pc + XLEN'(PCINC);
                nxt_d.step = (cur_q.ir.opc == OPC_HALT) ? ST_HALT : ST_EX;
            end
            ST_EX: begin
                if (cur_q.ir.opc == OPC_LD) begin
                    nxt_d.mar = alu_sum;
                    nxt_d.rd  = 1'b1;
                end else begin
                    nxt_d.alu = alu_sum;
                end
                nxt_d.cond = alu_nz;
                nxt_d.step = ST_MEM;
            end
            ST_MEM: begin
                nxt_d.rd = 1'b0;
                if (cur_q.ir.opc == OPC_BNZ && cur_q.cond) begin
                    nxt_d.pc = cur_q.alu;
                end
                nxt_d.step = (cur_q.ir.opc == OPC_LD) ? ST_MEMW : ST_WB;
            end
            ST_MEMW: begin
                nxt_d.mdr  = mem_rdata;
                nxt_d.step = ST_WB;
            end
            ST_WB: begin
                if (cur_q.ir.opc == OPC_ADD) begin
                    wr_en_d   = 1'b1;
                    wr_data_d = cur_q.alu;
                end else if (cur_q.ir.opc == OPC_LD) begin
                    wr_en_d   = 1'b1;
                    wr_data_d = cur_q.mdr;
                end
                nxt_d.step = ST_IF;
            end
            default: begin
                nxt_d.rd   = 1'b0;
                nxt_d.step = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            cur_q.step <= ST_IF;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mem_addr = cur_q.mar;
    assign mem_rd   = cur_q.rd;
    assign halted   = (cur_q.step == ST_HALT);

    // R3: a read command never spans two cycles
    a_r3_read_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R3: while the fetch read is in flight the pins carry the PC
    a_r3_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.step == ST_IFW) |-> (mem_rd && mem_addr == cur_q.pc));

    // R4: decode moves the PC on by one word
    a_r4_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.step == ST_ID && cur_q.ir.opc != OPC_HALT) |=> (cur_q.pc == $past(cur_q.pc) + XLEN'(PCINC)));

    // R7: execute never redirects the PC, only the memory step may
    a_r7_pc_hold_ex: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.step == ST_EX) |=> $stable(cur_q.pc));

    // R9: halted is sticky
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R9: no memory traffic once halted
    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_rd);
endmodule

// File: tb/mc_core_tb.sv
`timescale 1ns/1ps
module mc_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr;
    logic        mem_rd;
    logic [31:0] mem_rdata;
    logic [3:0]  reg_sel = 4'd0;
    logic [31:0] reg_val;
    logic        halted;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem  [0:63];
    logic [31:0] mreg [0:15];
    logic [31:0] mpc;

    always #2 clk = ~clk;

    mc_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .reg_sel   (reg_sel),
        .reg_val   (reg_val),
        .halted    (halted)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:2]];
    end

    function automatic logic [31:0] enc(int op, int s1, int s2, int d, int imm);
        return {op[3:0], s1[3:0], s2[3:0], d[3:0], imm[15:0]};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one cycle of the reference model: compare ports, then advance
    task automatic cyc(string tag, logic rd, logic [31:0] addr, logic h);
        chk({tag, " rd/halted"}, {30'd0, mem_rd, halted}, {30'd0, rd, h});
        if (rd) chk({tag, " addr"}, mem_addr, addr);
        @(negedge clk);
    endtask

    task automatic run_prog();
        logic [31:0] w, pcn, sx, ea;
        logic [3:0]  op, s1, s2, d;
        rst_n = 1'b0;
        for (int i = 0; i < 16; i++) mreg[i] = '0;
        mpc = '0;
        repeat (3) @(negedge clk);
        reg_sel = 4'd4;
        #1;
        chk("R2 reset reg", reg_val, 32'd0);
        chk("R2 reset outputs", {30'd0, mem_rd, halted}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int n = 0; n < 4000; n++) begin
            w  = mem[mpc[7:2]];
            op = w[31:28]; s1 = w[27:24]; s2 = w[23:20]; d = w[19:16];
            sx = {{16{w[15]}}, w[15:0]};
            cyc("R3 fetch set", 1'b0, 32'd0, 1'b0);
            cyc("R3 R4 fetch read", 1'b1, mpc, 1'b0);
            cyc("R3 fetch load", 1'b0, 32'd0, 1'b0);
            cyc("R1 decode", 1'b0, 32'd0, 1'b0);
            if (op == 4'd15) begin
                for (int k = 0; k < 6; k++) cyc("R9 halted", 1'b0, 32'd0, 1'b1);
                break;
            end
            pcn = mpc + 32'd4;
            cyc("R1 execute", 1'b0, 32'd0, 1'b0);
            case (op)
                4'd2: begin
                    ea = mreg[s1] + sx;
                    cyc("R6 data read", 1'b1, ea, 1'b0);
                    cyc("R6 data load", 1'b0, 32'd0, 1'b0);
                    cyc("R6 writeback", 1'b0, 32'd0, 1'b0);
                    mreg[d] = mem[ea[7:2]];
                    mpc = pcn;
                end
                4'd1: begin
                    cyc("R5 mem step", 1'b0, 32'd0, 1'b0);
                    cyc("R5 writeback", 1'b0, 32'd0, 1'b0);
                    mreg[d] = mreg[s1] + mreg[s2];
                    mpc = pcn;
                end
                4'd3: begin
                    cyc("R7 mem step", 1'b0, 32'd0, 1'b0);
                    cyc("R7 writeback", 1'b0, 32'd0, 1'b0);
                    mpc = (mreg[s1] != 0) ? pcn + sx : pcn;
                end
                default: begin
                    cyc("R8 mem step", 1'b0, 32'd0, 1'b0);
                    cyc("R8 writeback", 1'b0, 32'd0, 1'b0);
                    mpc = pcn;
                end
            endcase
        end
        for (int r = 0; r < 16; r++) begin
            reg_sel = r[3:0];
            #1;
            chk($sformatf("R10 reg %0d", r), reg_val, mreg[r]);
        end
    endtask

    task automatic peek(string tag, int r, logic [31:0] exp);
        reg_sel = r[3:0];
        #1;
        chk(tag, reg_val, exp);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        // program 1: sum of the first 100 odd numbers
        mem[0]  = enc(2, 0, 0, 1, 64);
        mem[1]  = enc(2, 0, 0, 3, 68);
        mem[2]  = enc(2, 0, 0, 5, 72);
        mem[3]  = enc(2, 0, 0, 6, 76);
        mem[4]  = enc(1, 4, 3, 4, 0);
        mem[5]  = enc(1, 3, 6, 3, 0);
        mem[6]  = enc(1, 1, 5, 1, 0);
        mem[7]  = enc(3, 1, 0, 0, -16);
        mem[8]  = enc(15, 0, 0, 0, 0);
        mem[16] = 32'd100;
        mem[17] = 32'd1;
        mem[18] = 32'hFFFF_FFFF;
        mem[19] = 32'd2;
        run_prog();
        peek("R11 loop sum r4", 4, 32'd10000);
        peek("R11 loop counter r1", 1, 32'd0);
        peek("R11 odd step r3", 3, 32'd201);

        // program 2: negative displacement, undefined opcode, both branch outcomes
        for (int i = 0; i < 64; i++) mem[i] = '0;
        mem[0]  = enc(2, 0, 0, 7, 96);
        mem[1]  = enc(2, 7, 0, 8, -8);
        mem[2]  = 32'h7123_4567;
        mem[3]  = enc(3, 0, 0, 0, 8);
        mem[4]  = enc(1, 8, 8, 9, 0);
        mem[5]  = enc(3, 9, 0, 0, 4);
        mem[6]  = enc(2, 0, 0, 10, 112);
        mem[7]  = enc(15, 0, 0, 0, 0);
        mem[24] = 32'd120;
        mem[28] = 32'h1234_5678;
        run_prog();
        peek("R6 negative displacement r8", 8, 32'h1234_5678);
        peek("R5 add r9", 9, 32'h2468_ACF0);
        peek("R7 taken branch skipped load r10", 10, 32'd0);
        peek("R8 undefined opcode left r3", 3, 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected halt");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule